// File: doc/BRIEF.md
# Linear Chirp Phase Generator

This block produces the phase sequence of a linear frequency sweep. It holds two 32-bit accumulators. The first is the running frequency word, which starts at a programmed start word. Each transmit sample steps it by a programmed increment. The second is the phase accumulator, which adds the current frequency word on every sample. The phase therefore grows quadratically with the sample count, and the instantaneous frequency ramps linearly.

Frequency words are fractions of the sample rate. A start word of 0x80000000 begins the sweep at minus half the sample rate. An increment of 0x0199999A sweeps a 32 MHz sample stream from about -16 MHz to +16 MHz.

The pulse controller drives `gen_en`. While it is high, each `samp_stb` pulse advances the sweep, and the 16-bit two's-complement amplitude is registered next to the phase for a later rotation stage. A two-state machine sequences the block:

- `ST_IDLE` is the waiting state. It is entered on reset or when `gen_en` falls (transition RUN→IDLE).
- `ST_RUN` is the sweeping state. It is entered from `ST_IDLE` in the cycle where `gen_en` is high (transition IDLE→RUN). That edge reloads the start word and zeroes the phase.

Top module: `chirp_phase_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `phase_out`, `freq_out` and `amp_out` to 0 and `out_valid` to 0, and leaves the block in `ST_IDLE`.
- R2: In `ST_IDLE`, a clock edge with `gen_en` high does three things. It loads `freq_out` with `start_word`, clears `phase_out` to 0 and captures `amp_in` into `amp_out`. A `samp_stb` in that same cycle causes no step, and `out_valid` stays 0.
- R3: In `ST_RUN`, a clock edge with `gen_en` and `samp_stb` both high updates two values at once. `phase_out` becomes the old phase plus the old `freq_out`. `freq_out` becomes the old frequency plus `incr_word`. After N such steps from a start word S with increment I, the phase equals N·S + I·N(N−1)/2 modulo 2^32.
- R4: `out_valid` is 1 for exactly the one cycle that follows each stepping edge of R3, and 0 at all other times.
- R5: A clock edge with `gen_en` low does not change `phase_out`, `freq_out` or `amp_out`. At that edge `out_valid` goes to 0, any `samp_stb` is ignored, and the block moves to `ST_IDLE`.
- R6: Both accumulators wrap modulo 2^32 and give no overflow indication.
- R7: When `gen_en` goes low and then high again, the sweep restarts from `start_word` with phase 0, whatever values the accumulators held before.
- R8: `amp_out` takes `amp_in` only on a load edge (R2) or a stepping edge (R3), and holds its value otherwise.
- R9: In `ST_RUN`, a clock edge with `gen_en` high and `samp_stb` low leaves `phase_out`, `freq_out` and `amp_out` unchanged and sets `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| gen_en | input | 1 | Transmit enable from the pulse controller |
| samp_stb | input | 1 | Transmit sample strobe |
| start_word | input | 32 | Start frequency tuning word |
| incr_word | input | 32 | Frequency increment per sample |
| amp_in | input | 16 | Two's-complement amplitude |
| phase_out | output | 32 | Phase accumulator |
| freq_out | output | 32 | Current frequency word |
| amp_out | output | 16 | Registered amplitude |
| out_valid | output | 1 | One-cycle pulse after each step |

## Verification
The bench builds the block at its default widths: 32-bit accumulators and a 16-bit amplitude. At these widths it can use the real sweep words, with a half-rate start and the ±16 MHz increment. Start words near 2^32 bring the wrap of both accumulators within a few steps. A long sweep with the strobe on alternate cycles is also compared against the closed-form quadratic phase. That comparison is independent of the cycle-by-cycle reference model.

// File: rtl/chirp_pkg.sv
package chirp_pkg;

    // Sequencer states: waiting for enable, or sweeping.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } chirp_state_e;

endpackage

// File: rtl/chirp_ctrl.sv
module chirp_ctrl
    import chirp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic gen_en,
    input  logic samp_stb,
    output logic load_o,
    output logic step_o,
    output logic valid_o
);

    chirp_state_e state_q;
    chirp_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: IDLE->RUN on enable, RUN->IDLE when enable drops
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (gen_en)  state_d = ST_RUN;
            ST_RUN:  if (!gen_en) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the current state
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = gen_en;
            ST_RUN:  step_o = gen_en & samp_stb;
            default: begin
                load_o = 1'b0;
                step_o = 1'b0;
            end
        endcase
    end

    // Valid follows a stepping edge by one cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
        end else begin
            valid_o <= step_o;
        end
    end

endmodule

// File: rtl/chirp_accum.sv
module chirp_accum #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic [W-1:0] addend,
    output logic [W-1:0] acc
);

    // Wraps modulo 2^W; the carry out is dropped on purpose.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (load) begin
            acc <= load_val;
        end else if (step) begin
            acc <= acc + addend;
        end
    end

endmodule

// File: rtl/chirp_phase_gen.sv
module chirp_phase_gen #(
    parameter int ACC_W = 32,
    parameter int AMP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gen_en,
    input  logic             samp_stb,
    input  logic [ACC_W-1:0] start_word,
    input  logic [ACC_W-1:0] incr_word,
    input  logic [AMP_W-1:0] amp_in,
    output logic [ACC_W-1:0] phase_out,
    output logic [ACC_W-1:0] freq_out,
    output logic [AMP_W-1:0] amp_out,
    output logic             out_valid
);

    localparam logic [ACC_W-1:0] PHASE_ORIGIN = '0;

    logic load;
    logic step;

    chirp_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .gen_en   (gen_en),
        .samp_stb (samp_stb),
        .load_o   (load),
        .step_o   (step),
        .valid_o  (out_valid)
    );

    // Frequency word: loads the start word, steps by the increment
    chirp_accum #(.W(ACC_W)) u_freq (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (start_word),
        .step     (step),
        .addend   (incr_word),
        .acc      (freq_out)
    );

    // Phase: clears to zero, steps by the pre-update frequency word
    chirp_accum #(.W(ACC_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (PHASE_ORIGIN),
        .step     (step),
        .addend   (freq_out),
        .acc      (phase_out)
    );

    // Amplitude travels alongside the phase
    always_ff @(posedge clk) begin
        if (rst) begin
            amp_out <= '0;
        end else if (load || step) begin
            amp_out <= amp_in;
        end
    end

endmodule

// File: rtl/chirp_phase_gen_chk.sv
module chirp_phase_gen_chk #(
    parameter int ACC_W = 32,
    parameter int AMP_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             gen_en,
    input logic             samp_stb,
    input logic [ACC_W-1:0] start_word,
    input logic [ACC_W-1:0] incr_word,
    input logic [AMP_W-1:0] amp_in,
    input logic [ACC_W-1:0] phase_out,
    input logic [ACC_W-1:0] freq_out,
    input logic [AMP_W-1:0] amp_out,
    input logic             out_valid
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (phase_out == '0 && freq_out == '0 && amp_out == '0 && !out_valid));

    // R2
    restart_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gen_en) |=> (freq_out == $past(start_word) && phase_out == '0 && !out_valid));

    // R3
    freq_step_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> freq_out == $past(freq_out) + $past(incr_word));

    // R3
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> phase_out == $past(phase_out) + $past(freq_out));

    // R4
    valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(gen_en) && $past(samp_stb)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !gen_en |=> ($stable(phase_out) && $stable(freq_out) && $stable(amp_out) && !out_valid));

    // R8
    amp_capture_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> amp_out == $past(amp_in));

endmodule

bind chirp_phase_gen chirp_phase_gen_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .gen_en     (gen_en),
    .samp_stb   (samp_stb),
    .start_word (start_word),
    .incr_word  (incr_word),
    .amp_in     (amp_in),
    .phase_out  (phase_out),
    .freq_out   (freq_out),
    .amp_out    (amp_out),
    .out_valid  (out_valid)
);

// File: tb/tb_chirp_phase_gen.sv
module tb_chirp_phase_gen;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gen_en = 1'b0;
    logic        samp_stb = 1'b0;
    logic [31:0] start_word = '0;
    logic [31:0] incr_word = '0;
    logic [15:0] amp_in = '0;
    logic [31:0] phase_out;
    logic [31:0] freq_out;
    logic [15:0] amp_out;
    logic        out_valid;

    int n_chk = 0;
    int n_bad = 0;

    // Reference state, built from the requirements
    logic [31:0] m_phase = '0;
    logic [31:0] m_freq = '0;
    logic [15:0] m_amp = '0;
    logic        m_valid = 1'b0;
    logic        m_run = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    chirp_phase_gen dut (
        .clk        (clk),
        .rst        (rst),
        .gen_en     (gen_en),
        .samp_stb   (samp_stb),
        .start_word (start_word),
        .incr_word  (incr_word),
        .amp_in     (amp_in),
        .phase_out  (phase_out),
        .freq_out   (freq_out),
        .amp_out    (amp_out),
        .out_valid  (out_valid)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, update the reference at the
    // rising edge, compare one time unit later.
    task automatic tick(input string tag, input logic r, input logic e, input logic s);
        @(negedge clk);
        rst = r; gen_en = e; samp_stb = s;
        @(posedge clk);
        if (r) begin
            m_phase = '0; m_freq = '0; m_amp = '0; m_valid = 1'b0; m_run = 1'b0;
        end else if (!m_run) begin
            m_valid = 1'b0;
            if (e) begin
                m_freq = start_word; m_phase = '0; m_amp = amp_in; m_run = 1'b1;
            end
        end else if (!e) begin
            m_run = 1'b0; m_valid = 1'b0;
        end else if (s) begin
            m_phase = m_phase + m_freq;
            m_freq  = m_freq + incr_word;
            m_amp   = amp_in;
            m_valid = 1'b1;
        end else begin
            m_valid = 1'b0;
        end
        #1;
        check(tag, "phase", phase_out, m_phase);
        check(tag, "freq", freq_out, m_freq);
        check(tag, "amp", {16'h0, amp_out}, {16'h0, m_amp});
        check(tag, "valid", {31'h0, out_valid}, {31'h0, m_valid});
    endtask

    task automatic t_reset();
        tick("R1", 1'b1, 1'b0, 1'b0);
        tick("R1", 1'b1, 1'b1, 1'b1);
        tick("R1", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_sweep();
        logic [63:0] n;
        logic [31:0] closed;
        start_word = 32'h8000_0000;
        incr_word  = 32'h0199_999A;
        amp_in     = 16'd9946;
        tick("R2", 1'b0, 1'b1, 1'b1);  // load edge: strobe ignored
        check("R2", "phase zero", phase_out, 32'h0);
        for (int i = 0; i < 40; i++) begin
            amp_in = 16'(9946 + i);
            tick("R3", 1'b0, 1'b1, 1'b1);
            tick("R4", 1'b0, 1'b1, 1'b0);
        end
        n = 64'd40;
        closed = 32'(n * 64'h8000_0000 + 64'h0199_999A * (n * (n - 64'd1) / 64'd2));
        check("R3", "closed form", phase_out, closed);
        check("R8", "amp last", {16'h0, amp_out}, {16'h0, 16'(9946 + 39)});
    endtask

    task automatic t_gaps();
        amp_in = 16'hBEEF;
        for (int i = 0; i < 6; i++) tick("R9", 1'b0, 1'b1, 1'b0);
        check("R9", "amp held", {16'h0, amp_out}, {16'h0, 16'(9946 + 39)});
        tick("R4", 1'b0, 1'b1, 1'b1);
        tick("R4", 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_disabled();
        amp_in = 16'h1234;
        for (int i = 0; i < 8; i++) tick("R5", 1'b0, 1'b0, 1'(i % 2));
        check("R5", "valid low", {31'h0, out_valid}, 32'h0);
    endtask

    task automatic t_restart();
        start_word = 32'h0100_0000;
        incr_word  = 32'h0000_1000;
        amp_in     = 16'h7FFF;
        tick("R7", 1'b0, 1'b1, 1'b0);
        check("R7", "freq reload", freq_out, 32'h0100_0000);
        check("R7", "phase reload", phase_out, 32'h0);
        for (int i = 0; i < 5; i++) tick("R7", 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_wrap();
        tick("R5", 1'b0, 1'b0, 1'b0);
        start_word = 32'hFFFF_FFF0;
        incr_word  = 32'h0000_0008;
        amp_in     = 16'h8000;
        tick("R6", 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) tick("R6", 1'b0, 1'b1, 1'b1);
        // freq: FFFFFFF0 -> ...F8 -> 0 -> 8; phase wraps past 2^32 as well
        check("R6", "freq wrapped", freq_out, 32'h0000_0020);
    endtask

    task automatic t_midreset();
        tick("R1", 1'b1, 1'b1, 1'b1);
        check("R1", "phase cleared", phase_out, 32'h0);
        tick("R2", 1'b0, 1'b1, 1'b0);  // enable held high through reset: loads
        tick("R3", 1'b0, 1'b1, 1'b1);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_gaps();
        t_disabled();
        t_restart();
        t_wrap();
        t_midreset();
        tick("R5", 1'b0, 1'b0, 1'b0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule